// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM

This block is a synchronous pipelined static memory with a double-data-rate data port and a fixed burst of two words. It runs on one reference clock that has two edges per word-pair period. A phase input, `k_phase`, tells the block which edges are positive-phase edges (`k_phase` = 1) and which are negative-phase edges (`k_phase` = 0). Commands are accepted only on positive-phase edges, so at most one burst starts every two data beats. The word address is split into two parts. The upper bits select a word pair. Bit 0 seeds a one-bit burst counter, which sets the order in which the two words of the pair are transferred.

Write data arrives one word per edge, each word with its own active-low byte enables. Both words are committed to the array together on the negative-phase edge that carries the second beat. Read data comes back one word per edge, marked by `rvalid`. The read latency is chosen by `dll_mode`: one positive-clock period, or one and a half. A read that follows a write to the same pair in the very next slot receives the new bytes before they reach the array. When `dll_mode` is set, a lock counter keeps `ready` low after reset, and commands are refused until the counter has finished.

Top module: `burst2_ddr_sram`

## Requirements
- R1: With `dll_mode` = 0, `ready` is high as soon as reset ends. With `dll_mode` = 1, `ready` stays low after reset until 1024 positive-phase edges have occurred, and it stays high from that point on.
- R2: A command is accepted only on an edge where `k_phase` = 1, `cmd_n` = 0 and `ready` = 1. `rd_wr` = 1 selects a read and `rd_wr` = 0 selects a write. On any other edge the block returns no read data and leaves the array unchanged.
- R3: For a write accepted on edge E0, the data on the next positive-phase edge (E2) is stored at `addr`. The data on the negative-phase edge after that (E3) is stored at `addr` with bit 0 inverted.
- R4: Each write beat updates byte lane i, which is bits [i*9+8 : i*9] of the 36-bit word, only when `wbyte_n[i]` = 0. A lane whose enable is 1 keeps its old contents.
- R5: With `dll_mode` = 0, a read accepted on edge E0 drives the word at `addr` on `rdata` after edge E2. It then drives the word at `addr` with bit 0 inverted after edge E3.
- R6: With `dll_mode` = 1, the same two words appear one edge later than in R5, after edges E3 and E4.
- R7: `rvalid` is high exactly for the returned read beats. A burst always shows as two consecutive valid beats. `rdata` is all zeros whenever `rvalid` is low.
- R8: A read accepted in the slot directly after a write to the same word pair returns the merged result of that write. This covers both burst orders and any byte mask. Reads of other pairs are unaffected.
- R9: While `rst` is high and right after it is released, `rvalid` is 0 and `rdata` is 0.
- R10: Reads accepted on consecutive positive-phase edges produce an unbroken stream of valid beats, in command order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; each rising edge is one data beat |
| rst | input | 1 | Synchronous active-high reset |
| k_phase | input | 1 | 1 on positive-phase edges, 0 on negative-phase edges |
| dll_mode | input | 1 | 1 selects the longer read latency and the lock wait |
| cmd_n | input | 1 | Active-low command strobe for the current slot |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | AW (10) | Word address; bit 0 seeds the burst counter |
| wbyte_n | input | NB (4) | Active-low byte-lane enables for the current write beat |
| wdata | input | W (36) | Write data beat |
| rdata | output | W (36) | Read data beat, zero when idle |
| rvalid | output | 1 | High while `rdata` carries a read beat |
| ready | output | 1 | High once commands are accepted |

## Verification
The assertions assume that `k_phase` alternates on every clock edge, reset edges included. They also assume that `dll_mode` changes only while `rst` is high. Under these conditions, array reads and commits always fall on edges of opposite phase. The bench drives `k_phase` from a single beat task that toggles it on every call, and it changes `dll_mode` only together with a reset. It reads only locations that an earlier accepted write has filled, because the array itself is never cleared.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

  // Command encoding carried on rd_wr
  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } op_e;

  // Words in one burst; each lives in its own bank selected by the burst LSB
  localparam int unsigned BURST_LEN = 2;

endpackage

// File: rtl/b2s_lock.sv
module b2s_lock #(
  parameter int LOCK_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic k_phase,
  input  logic dll_mode,
  output logic ready
);

  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);

  logic [CW-1:0] cnt;

  // Counts positive-phase edges after reset and saturates at the limit
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (k_phase && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready = !dll_mode || (cnt == LIMIT);

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ready && $stable(dll_mode)) |=> ready) else $error("ready dropped"); // R1

endmodule

// File: rtl/b2s_bank.sv
module b2s_bank #(
  parameter int PW = 9,
  parameter int W  = 36,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wd,
  input  logic [NB-1:0] wm,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rq
);

  localparam int DEPTH = 1 << PW;
  localparam int BW    = W / NB;

  logic [W-1:0] mem [DEPTH];

  // Byte-enabled write port and registered read port
  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < NB; i++) begin
        if (wm[i]) mem[waddr][i*BW +: BW] <= wd[i*BW +: BW];
      end
    end
    if (re) rq <= mem[raddr];
  end

  AST_NO_RW_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    !(we && re)) else $error("commit and fetch collide"); // R3

endmodule

// File: rtl/b2s_cmd.sv
module b2s_cmd
  import b2s_pkg::*;
#(
  parameter int AW = 10,
  parameter int W  = 36,
  parameter int NB = 4,
  localparam int PW = AW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 k_phase,
  input  logic                 ready,
  input  logic                 cmd_n,
  input  logic                 rd_wr,
  input  logic [AW-1:0]        addr,
  input  logic [NB-1:0]        wbyte_n,
  input  logic [W-1:0]         wdata,
  output logic                 rd_req,
  output logic [PW-1:0]        rd_addr,
  output logic                 rd_v,
  output logic [PW-1:0]        rd_pair,
  output logic                 rd_lsb,
  output logic                 cm_en,
  output logic [PW-1:0]        cm_pair,
  output logic [1:0][W-1:0]    cm_data,
  output logic [1:0][NB-1:0]   cm_mask
);

  logic          acc;
  logic          is_rd;
  logic          wr_v;
  logic          cw_v;
  logic [PW-1:0] c_pair;
  logic          c_lsb;
  logic          cw_lsb;
  logic [W-1:0]  b0_data;
  logic [NB-1:0] b0_mask;

  assign is_rd = (op_e'(rd_wr) == OP_RD);
  assign acc   = k_phase && !cmd_n && ready;

  // Array fetch issued on the command edge itself
  assign rd_req  = acc && is_rd;
  assign rd_addr = addr[AW-1:1];

  // Slot state: updated only on positive-phase edges
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v <= 1'b0;
      wr_v <= 1'b0;
      cw_v <= 1'b0;
    end else if (k_phase) begin
      rd_v <= acc && is_rd;
      wr_v <= acc && !is_rd;
      cw_v <= wr_v;
    end
  end

  always_ff @(posedge clk) begin
    if (k_phase) begin
      if (acc) begin
        c_pair <= addr[AW-1:1];
        c_lsb  <= addr[0];
      end
      cm_pair <= c_pair;
      cw_lsb  <= c_lsb;
      b0_data <= wdata;
      b0_mask <= ~wbyte_n;
    end
  end

  assign rd_pair = c_pair;
  assign rd_lsb  = c_lsb;

  // Commit on the negative-phase edge that carries the second beat
  assign cm_en = cw_v && !k_phase;

  // Beat 0 goes to the bank named by the burst LSB, beat 1 to the other
  for (genvar b = 0; b < BURST_LEN; b++) begin : g_route
    assign cm_data[b] = (cw_lsb == 1'(b)) ? b0_data : wdata;
    assign cm_mask[b] = (cw_lsb == 1'(b)) ? b0_mask : ~wbyte_n;
  end

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (rst)
    k_phase != $past(k_phase)) else $error("phase did not alternate"); // R2

endmodule

// File: rtl/b2s_rdpath.sv
module b2s_rdpath
  import b2s_pkg::*;
#(
  parameter int PW = 9,
  parameter int W  = 36,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               k_phase,
  input  logic               dll_mode,
  input  logic               rd_v,
  input  logic [PW-1:0]      rd_pair,
  input  logic               rd_lsb,
  input  logic [1:0][W-1:0]  bank_q,
  input  logic               cm_en,
  input  logic [PW-1:0]      cm_pair,
  input  logic [1:0][W-1:0]  cm_data,
  input  logic [1:0][NB-1:0] cm_mask,
  output logic [W-1:0]       rdata,
  output logic               rvalid
);

  localparam int BW = W / NB;

  logic             fwd_hit;
  logic [1:0][W-1:0] merged;
  logic [W-1:0]     first_w;
  logic [W-1:0]     second_w;
  logic             hold_v, sr0_v, sr1_v;
  logic [W-1:0]     hold_d, sr0_d, sr1_d;

  // Write being committed on this edge targets the pair just fetched
  assign fwd_hit = cm_en && (cm_pair == rd_pair);

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
    for (genvar i = 0; i < NB; i++) begin : g_lane
      assign merged[b][i*BW +: BW] = (fwd_hit && cm_mask[b][i]) ?
                                     cm_data[b][i*BW +: BW] : bank_q[b][i*BW +: BW];
    end
  end

  assign first_w  = merged[rd_lsb];
  assign second_w = merged[~rd_lsb];

  // Beat stream: first word enters on the negative-phase edge, second
  // word one edge later; a second stage provides the extra half cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      sr0_v  <= 1'b0;
      sr0_d  <= '0;
      sr1_v  <= 1'b0;
      sr1_d  <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (!k_phase) begin
        sr0_v  <= rd_v;
        sr0_d  <= rd_v ? first_w : '0;
        hold_v <= rd_v;
        hold_d <= rd_v ? second_w : '0;
      end else begin
        sr0_v  <= hold_v;
        sr0_d  <= hold_d;
        hold_v <= 1'b0;
        hold_d <= '0;
      end
      sr1_v <= sr0_v;
      sr1_d <= sr0_d;
      if (dll_mode) begin
        rvalid <= sr1_v;
        rdata  <= sr1_d;
      end else begin
        rvalid <= sr0_v;
        rdata  <= sr0_d;
      end
    end
  end

  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |=> rvalid) else $error("lone read beat"); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0)) else $error("idle data not zero"); // R7

endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram
  import b2s_pkg::*;
#(
  parameter int AW       = 10,
  parameter int W        = 36,
  parameter int NB       = 4,
  parameter int LOCK_CYC = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          k_phase,
  input  logic          dll_mode,
  input  logic          cmd_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] wbyte_n,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          rvalid,
  output logic          ready
);

  localparam int PW = AW - 1;

  logic              rd_req;
  logic [PW-1:0]     rd_addr;
  logic              rd_v;
  logic [PW-1:0]     rd_pair;
  logic              rd_lsb;
  logic              cm_en;
  logic [PW-1:0]     cm_pair;
  logic [1:0][W-1:0] cm_data;
  logic [1:0][NB-1:0] cm_mask;
  logic [1:0][W-1:0] bank_q;

  b2s_lock #(.LOCK_CYC(LOCK_CYC)) i_lock (
    .clk      (clk),
    .rst      (rst),
    .k_phase  (k_phase),
    .dll_mode (dll_mode),
    .ready    (ready)
  );

  b2s_cmd #(.AW(AW), .W(W), .NB(NB)) i_cmd (
    .clk     (clk),
    .rst     (rst),
    .k_phase (k_phase),
    .ready   (ready),
    .cmd_n   (cmd_n),
    .rd_wr   (rd_wr),
    .addr    (addr),
    .wbyte_n (wbyte_n),
    .wdata   (wdata),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_v    (rd_v),
    .rd_pair (rd_pair),
    .rd_lsb  (rd_lsb),
    .cm_en   (cm_en),
    .cm_pair (cm_pair),
    .cm_data (cm_data),
    .cm_mask (cm_mask)
  );

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
    b2s_bank #(.PW(PW), .W(W), .NB(NB)) i_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (cm_en),
      .waddr (cm_pair),
      .wd    (cm_data[b]),
      .wm    (cm_mask[b]),
      .re    (rd_req),
      .raddr (rd_addr),
      .rq    (bank_q[b])
    );
  end

  b2s_rdpath #(.PW(PW), .W(W), .NB(NB)) i_rdpath (
    .clk      (clk),
    .rst      (rst),
    .k_phase  (k_phase),
    .dll_mode (dll_mode),
    .rd_v     (rd_v),
    .rd_pair  (rd_pair),
    .rd_lsb   (rd_lsb),
    .bank_q   (bank_q),
    .cm_en    (cm_en),
    .cm_pair  (cm_pair),
    .cm_data  (cm_data),
    .cm_mask  (cm_mask),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );

endmodule

// File: tb/test_burst2_ddr_sram.sv
module test_burst2_ddr_sram;

  localparam int AW = 10;
  localparam int W  = 36;
  localparam int NB = 4;
  localparam int BW = W / NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          k_phase = 1'b1;
  logic          dll_mode = 1'b0;
  logic          cmd_n = 1'b1;
  logic          rd_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] wbyte_n = '1;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rvalid;
  logic          ready;

  int vectors = 0;
  int miscomp = 0;
  int bn = 0;

  logic          rv_log [64];
  logic [W-1:0]  rd_log [64];
  logic [W-1:0]  model [1 << AW];

  logic [W-1:0]  pend_d0 = '0, pend_d1 = '0;
  logic [NB-1:0] pend_m0 = '1, pend_m1 = '1;

  always #10 clk = ~clk;

  burst2_ddr_sram #(.AW(AW), .W(W), .NB(NB)) i_burst2_ddr_sram (
    .clk(clk), .rst(rst), .k_phase(k_phase), .dll_mode(dll_mode),
    .cmd_n(cmd_n), .rd_wr(rd_wr), .addr(addr), .wbyte_n(wbyte_n),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .ready(ready)
  );

  function automatic logic [W-1:0] mrg(logic [W-1:0] old, logic [W-1:0] nw, logic [NB-1:0] mn);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < NB; i++) if (!mn[i]) r[i*BW +: BW] = nw[i*BW +: BW];
    return r;
  endfunction

  task automatic chkv(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One reference-clock edge: drive, pass the edge, sample at the negedge
  task automatic beat(input logic ph, input logic ldn, input logic rw, input logic [AW-1:0] a,
                      input logic [W-1:0] d, input logic [NB-1:0] mn);
    k_phase = ph; cmd_n = ldn; rd_wr = rw; addr = a; wdata = d; wbyte_n = mn;
    @(negedge clk);
    rv_log[bn % 64] = rvalid;
    rd_log[bn % 64] = rdata;
    bn++;
  endtask

  // One command slot: positive-phase edge then negative-phase edge
  task automatic kslot(input logic ldn, input logic rw, input logic [AW-1:0] a,
                       input logic [W-1:0] d0, input logic [W-1:0] d1,
                       input logic [NB-1:0] m0n, input logic [NB-1:0] m1n, output int s);
    logic acc;
    acc = !ldn && ready && !rst;
    s = bn;
    beat(1'b1, ldn, rw, a, pend_d0, pend_m0);
    beat(1'b0, 1'b1, 1'b0, '0, pend_d1, pend_m1);
    if (acc && !rw) begin
      model[a] = mrg(model[a], d0, m0n);
      model[a ^ AW'(1)] = mrg(model[a ^ AW'(1)], d1, m1n);
      pend_d0 = d0; pend_d1 = d1; pend_m0 = m0n; pend_m1 = m1n;
    end else begin
      pend_d0 = '0; pend_d1 = '0; pend_m0 = '1; pend_m1 = '1;
    end
  endtask

  task automatic idle(input int n);
    int s;
    for (int k = 0; k < n; k++) kslot(1'b1, 1'b0, '0, '0, '0, '1, '1, s);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                    input logic [NB-1:0] m0n, input logic [NB-1:0] m1n);
    int s;
    kslot(1'b0, 1'b0, a, d0, d1, m0n, m1n, s);
  endtask

  task automatic rd(input logic [AW-1:0] a, output int s, output logic [W-1:0] e0, output logic [W-1:0] e1);
    kslot(1'b0, 1'b1, a, '0, '0, '1, '1, s);
    e0 = model[a];
    e1 = model[a ^ AW'(1)];
  endtask

  task automatic chk_read(input int s, input int lat, input bit pre, input logic [W-1:0] e0,
                          input logic [W-1:0] e1, input string tag);
    int i;
    i = s + 2 + lat;
    if (pre) chkv({tag, " no early beat"}, 64'(rv_log[(i-1) % 64]), 64'(1'b0));
    chkv({tag, " beat0 valid"}, 64'(rv_log[i % 64]), 64'(1'b1));
    chkv({tag, " beat0 data"}, 64'(rd_log[i % 64]), 64'(e0));
    chkv({tag, " beat1 valid"}, 64'(rv_log[(i+1) % 64]), 64'(1'b1));
    chkv({tag, " beat1 data"}, 64'(rd_log[(i+1) % 64]), 64'(e1));
  endtask

  task automatic t_reset();
    dll_mode = 1'b0; rst = 1'b1;
    idle(3);
    chkv("R9 rvalid in reset", 64'(rvalid), 64'(1'b0));
    chkv("R9 rdata in reset", 64'(rdata), 64'(0));
    chkv("R1 ready with dll off", 64'(ready), 64'(1'b1));
    rst = 1'b0;
    idle(1);
    chkv("R9 rvalid after reset", 64'(rvalid), 64'(1'b0));
  endtask

  task automatic t_burst_order();
    int s1, s2;
    logic [W-1:0] a0, a1, b0, b1;
    wr(10'd10, 36'h1_1111_1111, 36'h2_2222_2222, '0, '0);
    wr(10'd21, 36'h3_3333_3333, 36'h4_4444_4444, '0, '0);
    idle(1);
    rd(10'd10, s1, a0, a1);
    rd(10'd21, s2, b0, b1);
    idle(3);
    chk_read(s1, 0, 1'b1, a0, a1, "R3 R5 even start");
    chk_read(s2, 0, 1'b0, b0, b1, "R3 R5 odd start");
    chkv("R7 valid drops after burst", 64'(rv_log[(s2 + 4) % 64]), 64'(1'b0));
    chkv("R3 odd start second word", 64'(b1), 64'(36'h4_4444_4444));
  endtask

  task automatic t_bytemask();
    int s;
    logic [W-1:0] e0, e1;
    wr(10'd10, 36'hA_AAAA_AAAA, 36'hB_BBBB_BBBB, 4'b1010, 4'b0111);
    idle(1);
    rd(10'd10, s, e0, e1);
    idle(3);
    chk_read(s, 0, 1'b1, e0, e1, "R4 masked lanes");
  endtask

  task automatic t_forward();
    int s;
    logic [W-1:0] e0, e1;
    wr(10'd40, 36'h5_0505_0505, 36'h6_0606_0606, '0, '0);
    idle(1);
    wr(10'd40, 36'h7_7777_7777, 36'h8_8888_8888, 4'b0011, 4'b1100);
    rd(10'd41, s, e0, e1);
    idle(3);
    chk_read(s, 0, 1'b1, e0, e1, "R8 opposite lsb masked");
    wr(10'd42, 36'h9_1234_5678, 36'h0_8765_4321, '0, '0);
    rd(10'd42, s, e0, e1);
    idle(3);
    chk_read(s, 0, 1'b1, e0, e1, "R8 same lsb");
    wr(10'd50, 36'hC_CCCC_CCCC, 36'hD_DDDD_DDDD, '0, '0);
    rd(10'd40, s, e0, e1);
    idle(3);
    chk_read(s, 0, 1'b1, e0, e1, "R8 other pair untouched");
  endtask

  task automatic t_ignore();
    int s, r;
    logic [W-1:0] e0, e1;
    kslot(1'b1, 1'b1, 10'd10, '0, '0, '1, '1, s);
    idle(2);
    for (int k = 2; k <= 4; k++) begin
      chkv("R2 strobe high no beat", 64'(rv_log[(s + k) % 64]), 64'(1'b0));
      chkv("R7 idle data zero", 64'(rd_log[(s + k) % 64]), 64'(0));
    end
    // Write and read attempted on negative-phase edges
    beat(1'b1, 1'b1, 1'b0, '0, '0, '1);
    beat(1'b0, 1'b0, 1'b0, 10'd10, '0, '1);
    beat(1'b1, 1'b1, 1'b0, '0, 36'hF_0F0F_0F0F, '0);
    r = bn;
    beat(1'b0, 1'b0, 1'b1, 10'd10, 36'hE_E0E0_E0E0, '0);
    idle(2);
    for (int k = 1; k <= 4; k++)
      chkv("R2 negative-phase read ignored", 64'(rv_log[(r + k) % 64]), 64'(1'b0));
    rd(10'd10, s, e0, e1);
    idle(3);
    chk_read(s, 0, 1'b1, e0, e1, "R2 array unchanged");
  endtask

  task automatic t_lock();
    int s;
    logic [W-1:0] e0, e1;
    dll_mode = 1'b1; rst = 1'b1;
    idle(3);
    rst = 1'b0;
    chkv("R1 ready low after reset", 64'(ready), 64'(1'b0));
    wr(10'd10, 36'h0_DEAD_BEEF, 36'h0_BAD0_CAFE, '0, '0);
    for (int k = 0; k < 1022; k++) idle(1);
    chkv("R1 ready low at 1023 edges", 64'(ready), 64'(1'b0));
    idle(1);
    chkv("R1 ready high at 1024 edges", 64'(ready), 64'(1'b1));
    rd(10'd10, s, e0, e1);
    idle(3);
    chk_read(s, 1, 1'b1, e0, e1, "R2 write before ready refused");
  endtask

  task automatic t_dll_latency();
    int s;
    logic [W-1:0] e0, e1;
    rd(10'd21, s, e0, e1);
    idle(3);
    chkv("R6 nothing at short latency", 64'(rv_log[(s + 2) % 64]), 64'(1'b0));
    chk_read(s, 1, 1'b1, e0, e1, "R6 long latency");
    wr(10'd42, 36'h1_CAFE_0001, 36'h2_CAFE_0002, 4'b0101, '0);
    rd(10'd43, s, e0, e1);
    idle(3);
    chk_read(s, 1, 1'b1, e0, e1, "R8 R6 forward long latency");
  endtask

  task automatic t_stream();
    int s [4];
    logic [W-1:0] e0 [4], e1 [4];
    logic [AW-1:0] al [4];
    al[0] = 10'd10; al[1] = 10'd20; al[2] = 10'd41; al[3] = 10'd50;
    for (int k = 0; k < 4; k++) rd(al[k], s[k], e0[k], e1[k]);
    idle(3);
    for (int k = 0; k < 4; k++) chk_read(s[k], 1, (k == 0), e0[k], e1[k], "R10 stream");
    chkv("R10 valid ends after stream", 64'(rv_log[(s[3] + 5) % 64]), 64'(1'b0));
  endtask

  initial begin
    t_reset();
    t_burst_order();
    t_bytemask();
    t_forward();
    t_ignore();
    t_lock();
    t_dll_latency();
    t_stream();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog: got %0d cycles expected fewer", 200000);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule